// File: doc/BRIEF.md
# Masked-Match Packet Flow Classifier

This block assigns a flow identifier to a packet from a handful of IP header fields. The fields arrive on separate input ports. They are joined into a single 112-bit search key, and that key is compared at the same time with every row of a small rule table. Each row has a value word, a per-bit mask word, a 16-bit flow identifier and a valid flag.

A row matches when every key bit that its mask enables equals the row's value bit. Key bits whose mask bit is clear are ignored. When several rows match, the row with the lowest index wins. The classification result is registered and is available one clock after the search request. It consists of a hit flag and the winning flow identifier, which is zero on a miss.

Rules are loaded through a single-row write port. Each write replaces the value, mask, flow identifier and valid flag of the addressed row in one cycle. A search issued in the same cycle as a write still sees the table as it was before that write.

Top module: `flow_classifier`

## Requirements
- R1: After reset, res_valid, res_hit and res_fid are 0 and every table row is invalid, so a search made before any write misses.
- R2: The search key is {src_addr, dst_addr, src_port, dst_port, proto, payload_bits}, with src_addr in key bits [111:80], dst_addr in [79:48], src_port in [47:32], dst_port in [31:16], proto in [15:8] and payload_bits in [7:0]. Rule value and mask words use the same bit positions.
- R3: A valid row matches when ((key ^ value) & mask) == 0. A mask bit of 1 requires that key bit to equal the value bit. A mask bit of 0 ignores that key bit.
- R4: A row whose valid flag was written as 0 never matches, whatever its value and mask.
- R5: When several valid rows match, the result carries the flow identifier of the lowest-indexed matching row.
- R6: When no valid row matches, res_hit is 0 and res_fid is 0.
- R7: res_valid is 1 exactly in the cycle after a cycle with key_valid = 1. Otherwise it is 0. The result reflects the key sampled at that edge.
- R8: A write and a search at the same clock edge: the search uses the old row contents, and the following search uses the new ones.
- R9: While key_valid is 0, res_hit and res_fid keep their last values, whatever the key inputs do.
- R10: A valid row with an all-zero mask matches every key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Search request for the key fields below |
| src_addr | input | 32 | Source IP address field |
| dst_addr | input | 32 | Destination IP address field |
| src_port | input | 16 | Source port field |
| dst_port | input | 16 | Destination port field |
| proto | input | 8 | Protocol field |
| payload_bits | input | 8 | Payload match bits |
| wr_en | input | 1 | Write one table row |
| wr_idx | input | IDX_W (3) | Row index to write |
| wr_value | input | 112 | Row value word, key layout |
| wr_mask | input | 112 | Row mask word, 1 = compare |
| wr_fid | input | FID_W (16) | Row flow identifier |
| wr_valid | input | 1 | Row valid flag |
| res_valid | output | 1 | Result present this cycle |
| res_hit | output | 1 | Some valid row matched |
| res_fid | output | FID_W (16) | Winning flow identifier, 0 on miss |

## Verification
The table is filled with one exact-match row and six rows that each compare a single header field. A row with an all-zero mask is first written as invalid and later made valid. Keys that touch only one field check that each field reaches its intended key slice. Keys with swapped fields (source and destination ports, source and destination addresses) must miss, which separates a correct layout from a transposed one. A single-bit difference inside a compared field must also miss. Keys that satisfy several rows at once separate the lowest-index choice from any other ordering. Directed steps then cover a write that coincides with a search and the holding of the result while no search is made.

// File: rtl/flowcls_pkg.sv
package flowcls_pkg;

  localparam int SRC_W   = 32;
  localparam int DST_W   = 32;
  localparam int PORT_W  = 16;
  localparam int PROTO_W = 8;
  localparam int PAY_W   = 8;
  localparam int KEY_W   = SRC_W + DST_W + 2 * PORT_W + PROTO_W + PAY_W;

  // Field order from most to least significant key bit.
  typedef struct packed {
    logic [SRC_W-1:0]   src_addr;
    logic [DST_W-1:0]   dst_addr;
    logic [PORT_W-1:0]  src_port;
    logic [PORT_W-1:0]  dst_port;
    logic [PROTO_W-1:0] proto;
    logic [PAY_W-1:0]   payload;
  } hdr_fields_t;

  function automatic logic [KEY_W-1:0] pack_key(input hdr_fields_t h);
    return KEY_W'(h);
  endfunction

  // Ternary compare: a set mask bit demands equality, a clear one ignores the bit.
  function automatic logic rule_hits(input logic [KEY_W-1:0] key,
                                     input logic [KEY_W-1:0] value,
                                     input logic [KEY_W-1:0] mask,
                                     input logic             valid);
    return valid && (((key ^ value) & mask) == '0);
  endfunction

endpackage

// File: rtl/fcl_rule_table.sv
module fcl_rule_table #(
  parameter int N     = 8,
  parameter int KW    = 112,
  parameter int FW    = 16,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [KW-1:0] wr_value,
  input  logic [KW-1:0] wr_mask,
  input  logic [FW-1:0] wr_fid,
  input  logic          wr_valid,
  output logic [KW-1:0] tbl_value [N],
  output logic [KW-1:0] tbl_mask  [N],
  output logic [FW-1:0] tbl_fid   [N],
  output logic [N-1:0]  tbl_valid
);

  logic [N-1:0] row_sel;

  for (genvar i = 0; i < N; i++) begin : g_row
    assign row_sel[i] = wr_en && (wr_idx == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_value[i] <= '0;
        tbl_mask[i]  <= '0;
        tbl_fid[i]   <= '0;
        tbl_valid[i] <= 1'b0;
      end else if (row_sel[i]) begin
        tbl_value[i] <= wr_value;
        tbl_mask[i]  <= wr_mask;
        tbl_fid[i]   <= wr_fid;
        tbl_valid[i] <= wr_valid;
      end
    end
  end

  // R4 / R8: the addressed row's valid flag takes the written value one edge later.
  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_idx) < N)) |=> (tbl_valid[$past(wr_idx)] == $past(wr_valid)));

  // R8: at most one row is selected for writing in a cycle.
  p_single_row_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

endmodule

// File: rtl/fcl_match_array.sv
module fcl_match_array
  import flowcls_pkg::*;
#(
  parameter int N  = 8,
  parameter int KW = KEY_W
) (
  input  logic [KW-1:0] key,
  input  logic [KW-1:0] tbl_value [N],
  input  logic [KW-1:0] tbl_mask  [N],
  input  logic [N-1:0]  tbl_valid,
  output logic [N-1:0]  match_vec
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match_vec[i] = rule_hits(key, tbl_value[i], tbl_mask[i], tbl_valid[i]);
  end

endmodule

// File: rtl/fcl_prio_pick.sv
module fcl_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  match_vec,
  output logic [N-1:0]  grant_vec,
  output logic [IW-1:0] win_idx,
  output logic          any_hit
);

  always_comb begin
    win_idx   = '0;
    grant_vec = '0;
    any_hit   = |match_vec;
    // Scan from the top down so the lowest set index is the last one kept.
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        win_idx = IW'(i);
      end
    end
    if (any_hit) begin
      grant_vec[win_idx] = 1'b1;
    end
  end

endmodule

// File: rtl/flow_classifier.sv
module flow_classifier
  import flowcls_pkg::*;
#(
  parameter int NUM_RULES = 8,
  parameter int FID_W     = 16,
  localparam int IDX_W    = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_valid,
  input  logic [SRC_W-1:0]   src_addr,
  input  logic [DST_W-1:0]   dst_addr,
  input  logic [PORT_W-1:0]  src_port,
  input  logic [PORT_W-1:0]  dst_port,
  input  logic [PROTO_W-1:0] proto,
  input  logic [PAY_W-1:0]   payload_bits,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [KEY_W-1:0]   wr_value,
  input  logic [KEY_W-1:0]   wr_mask,
  input  logic [FID_W-1:0]   wr_fid,
  input  logic               wr_valid,
  output logic               res_valid,
  output logic               res_hit,
  output logic [FID_W-1:0]   res_fid
);

  hdr_fields_t          hdr;
  logic [KEY_W-1:0]     search_key;
  logic [KEY_W-1:0]     tbl_value [NUM_RULES];
  logic [KEY_W-1:0]     tbl_mask  [NUM_RULES];
  logic [FID_W-1:0]     tbl_fid   [NUM_RULES];
  logic [NUM_RULES-1:0] tbl_valid;
  logic [NUM_RULES-1:0] match_vec;
  logic [NUM_RULES-1:0] grant_vec;
  logic [IDX_W-1:0]     win_idx;
  logic                 any_hit;
  logic [FID_W-1:0]     win_fid;

  assign hdr.src_addr = src_addr;
  assign hdr.dst_addr = dst_addr;
  assign hdr.src_port = src_port;
  assign hdr.dst_port = dst_port;
  assign hdr.proto    = proto;
  assign hdr.payload  = payload_bits;
  assign search_key   = pack_key(hdr);

  fcl_rule_table #(
    .N (NUM_RULES), .KW(KEY_W), .FW(FID_W), .IW(IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_value (wr_value),
    .wr_mask  (wr_mask),
    .wr_fid   (wr_fid),
    .wr_valid (wr_valid),
    .tbl_value(tbl_value),
    .tbl_mask (tbl_mask),
    .tbl_fid  (tbl_fid),
    .tbl_valid(tbl_valid)
  );

  fcl_match_array #(
    .N (NUM_RULES), .KW(KEY_W)
  ) u_match (
    .key      (search_key),
    .tbl_value(tbl_value),
    .tbl_mask (tbl_mask),
    .tbl_valid(tbl_valid),
    .match_vec(match_vec)
  );

  fcl_prio_pick #(
    .N (NUM_RULES), .IW(IDX_W)
  ) u_pick (
    .match_vec(match_vec),
    .grant_vec(grant_vec),
    .win_idx  (win_idx),
    .any_hit  (any_hit)
  );

  assign win_fid = any_hit ? tbl_fid[win_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fid   <= '0;
    end else begin
      res_valid <= key_valid;
      if (key_valid) begin
        res_hit <= any_hit;
        res_fid <= win_fid;
      end
    end
  end

  // R7: a request produces a result on the next cycle.
  p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> res_valid);

  // R7: no result without a request.
  p_no_stray_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> !res_valid);

  // R3: the hit flag reflects the comparator outputs at the request edge.
  p_hit_from_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> (res_hit == $past(|match_vec)));

  // R6: a miss reports the default identifier.
  p_miss_zero_fid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_fid == '0));

  // R9: results hold while no search is made.
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> ($stable(res_hit) && $stable(res_fid)));

  // R5: at most one winner, and only among matching rows.
  p_grant_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && ((grant_vec & ~match_vec) == '0));

  // R5: no matching row sits below the winner.
  p_grant_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((match_vec & (grant_vec - 1'b1)) == '0));

endmodule

// File: tb/flow_classifier_tb_top.sv
module flow_classifier_tb_top;

  localparam int CLK_P = 10;
  localparam int KW    = 112;
  localparam int FW    = 16;
  localparam int VW    = KW + 1 + FW;
  localparam int NV    = 14;

  // Keys per R2: {src32, dst32, sport16, dport16, proto8, pay8}; then hit, fid.
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0,        32'h0,        16'h0,    16'h0,    8'h11, 8'h00, 1'b0, 16'h0000},
    {32'h0,        32'h0,        16'h0,    16'h0,    8'h06, 8'h00, 1'b1, 16'h0B02},
    {32'h0,        32'hC0A80001, 16'h0,    16'h0,    8'h11, 8'h00, 1'b1, 16'h0C03},
    {32'h0,        32'h0,        16'h1234, 16'h0,    8'h11, 8'h00, 1'b1, 16'h0D04},
    {32'h0,        32'h0,        16'h0,    16'h0050, 8'h11, 8'h00, 1'b1, 16'h0E05},
    {32'h0,        32'h0,        16'h0,    16'h0,    8'h11, 8'hA5, 1'b1, 16'h0F06},
    {32'h0A000001, 32'h0,        16'h0,    16'h0,    8'h11, 8'h00, 1'b1, 16'h1007},
    {32'h0A000001, 32'hC0A80001, 16'h1234, 16'h0050, 8'h06, 8'hA5, 1'b1, 16'h0A01},
    {32'h0A000001, 32'hC0A80001, 16'h1234, 16'h0050, 8'h06, 8'hA4, 1'b1, 16'h0B02},
    {32'h0,        32'hC0A80001, 16'h0,    16'h0050, 8'h11, 8'h00, 1'b1, 16'h0C03},
    {32'h0,        32'h0,        16'h0050, 16'h1234, 8'h11, 8'h00, 1'b0, 16'h0000},
    {32'hC0A80001, 32'h0A000001, 16'h0,    16'h0,    8'h11, 8'h00, 1'b0, 16'h0000},
    {32'h0,        32'hC0A80000, 16'h0,    16'h0,    8'h11, 8'h00, 1'b0, 16'h0000},
    {32'h0A000001, 32'h0,        16'h0,    16'h0,    8'h06, 8'h00, 1'b1, 16'h0B02}
  };

  localparam logic [KW-1:0] KEY_A =
    {32'h0A000001, 32'hC0A80001, 16'h1234, 16'h0050, 8'h06, 8'hA5};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          key_valid = 1'b0;
  logic [31:0]   src_addr = '0, dst_addr = '0;
  logic [15:0]   src_port = '0, dst_port = '0;
  logic [7:0]    proto = '0, payload_bits = '0;
  logic          wr_en = 1'b0, wr_valid = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [KW-1:0] wr_value = '0, wr_mask = '0;
  logic [FW-1:0] wr_fid = '0;
  logic          res_valid, res_hit;
  logic [FW-1:0] res_fid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  flow_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_port(src_port),
    .dst_port(dst_port), .proto(proto), .payload_bits(payload_bits),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value), .wr_mask(wr_mask),
    .wr_fid(wr_fid), .wr_valid(wr_valid),
    .res_valid(res_valid), .res_hit(res_hit), .res_fid(res_fid)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_key(input logic [KW-1:0] k);
    src_addr     = k[111:80];
    dst_addr     = k[79:48];
    src_port     = k[47:32];
    dst_port     = k[31:16];
    proto        = k[15:8];
    payload_bits = k[7:0];
  endtask

  task automatic put_row(input int idx, input logic [KW-1:0] v,
                         input logic [KW-1:0] m, input logic [FW-1:0] f,
                         input logic vld);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_value = v; wr_mask = m;
    wr_fid = f; wr_valid = vld;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Search: drive at a falling edge, result is registered at the next rising edge.
  task automatic search(input logic [KW-1:0] k, input string req,
                        input logic exp_hit, input logic [FW-1:0] exp_fid);
    @(negedge clk);
    set_key(k); key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    check("R7", {req, " valid"}, 32'(res_valid), 32'd1);
    check(req, "hit", 32'(res_hit), 32'(exp_hit));
    check(req, "fid", 32'(res_fid), 32'(exp_fid));
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs.
    check("R1", "res_valid", 32'(res_valid), 32'd0);
    check("R1", "res_hit",   32'(res_hit),   32'd0);
    check("R1", "res_fid",   32'(res_fid),   32'd0);
    rst_n = 1'b1;
    // R1: empty table misses even an all-zero key.
    search('0, "R1", 1'b0, 16'h0);

    // R2 field slices in every rule below.
    put_row(0, KEY_A, {KW{1'b1}}, 16'h0A01, 1'b1);
    put_row(1, {104'h0, 8'h06, 8'h00}, {104'h0, 8'hFF, 8'h00}, 16'h0B02, 1'b1);
    put_row(2, {32'h0, 32'hC0A80001, 48'h0}, {32'h0, 32'hFFFFFFFF, 48'h0}, 16'h0C03, 1'b1);
    put_row(3, {64'h0, 16'h1234, 32'h0}, {64'h0, 16'hFFFF, 32'h0}, 16'h0D04, 1'b1);
    put_row(4, {80'h0, 16'h0050, 16'h0}, {80'h0, 16'hFFFF, 16'h0}, 16'h0E05, 1'b1);
    put_row(5, {104'h0, 8'hA5}, {104'h0, 8'hFF}, 16'h0F06, 1'b1);
    put_row(6, {32'h0A000001, 80'h0}, {32'hFFFFFFFF, 80'h0}, 16'h1007, 1'b1);
    // R4: wildcard row stored invalid.
    put_row(7, '0, '0, 16'h1108, 1'b0);

    // Vector walk: R2 layout, R3 masking, R4 invalid row, R5 priority, R6 miss.
    for (int v = 0; v < NV; v++) begin
      search(VEC[v][VW-1:FW+1], $sformatf("R2/R3/R4/R5/R6 vec%0d", v),
             VEC[v][FW], VEC[v][FW-1:0]);
    end

    // R10: validate the all-zero mask row; the neutral key now hits it.
    put_row(7, '0, '0, 16'h1108, 1'b1);
    search({64'h0, 32'h0, 8'h11, 8'h00}, "R10 wildcard", 1'b1, 16'h1108);
    search({64'h0, 32'h0, 8'h06, 8'h00}, "R10 lower row wins", 1'b1, 16'h0B02);

    // R8: invalidate row 0 at the same edge as a search for KEY_A.
    @(negedge clk);
    set_key(KEY_A); key_valid = 1'b1;
    wr_en = 1'b1; wr_idx = 3'd0; wr_value = KEY_A; wr_mask = {KW{1'b1}};
    wr_fid = 16'h0A01; wr_valid = 1'b0;
    @(negedge clk);
    key_valid = 1'b0; wr_en = 1'b0;
    check("R8", "same-edge hit", 32'(res_hit), 32'd1);
    check("R8", "same-edge fid", 32'(res_fid), 32'h0A01);
    search(KEY_A, "R8 next search", 1'b1, 16'h0B02);

    // R9: idle cycles with a changing key leave the result alone.
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      set_key({32'h0, 32'hC0A80001, 16'h0, 16'h0, 8'h11, 8'(c)});
      @(negedge clk);
      check("R7", "idle res_valid", 32'(res_valid), 32'd0);
      check("R9", "held hit", 32'(res_hit), 32'd1);
      check("R9", "held fid", 32'(res_fid), 32'h0B02);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule